// File: doc/BRIEF.md
# CAN Message Object Status Handler

This block holds the four status flags of every CAN message object: transmit request, new data, interrupt pending and valid. Each object also keeps three configuration bits that steer how it reacts to incoming remote frames: direction, remote-enable and use-mask. Two sources update the flags. The CPU side issues command writes to one object at a time. The protocol engine reports three kinds of event against an object: frame transmitted, data frame received and remote frame received.

Software reads the flags as packed 16-bit words that it cannot write. Each flag type has a low word and a high word. The block also reports the number of the pending-interrupt object with the highest priority. Objects are numbered from 1. A command or event that names object 0, or a number above the object count, touches nothing.

Top module: `can_msg_status`

## Requirements
- R1: After reset every status word, `int_id` and `tx_ok` are 0.
- R2: For every flag type, object k (1..16) appears at bit k-1 of the `_lo` word and object k (17..32) appears at bit k-17 of the `_hi` word. Status updates are visible in the cycle after the clock edge that takes the command or event.
- R3: A transmit-done event clears that object's transmit request and sets its interrupt pending. `tx_ok` is 1 for the one cycle after each transmit-done event. This holds even when the object's valid bit was cleared before the transmission finished.
- R4: A received remote frame sets the transmit request when the object has direction = 1 and remote-enable = 1.
- R5: A received remote frame clears the transmit request when the object has direction = 1, remote-enable = 0 and use-mask = 1.
- R6: In every other configuration, a received remote frame leaves the transmit request unchanged. This includes direction = 0, and remote-enable = 0 with use-mask = 0.
- R7: A command write with `cmd_ctrl` = 1 loads the object's transmit request, new data, interrupt pending, remote-enable and use-mask from the command inputs. Writing a 0 to transmit request clears it. A command write with `cmd_arb` = 1 loads valid and direction.
- R8: A received data frame sets the object's new data and interrupt pending bits.
- R9: `int_id` gives the lowest-numbered object whose interrupt-pending bit is set. It is 0 when no object is pending.
- R10: When a CPU command clear and a protocol-engine set hit the same bit in the same cycle, the bit ends up set.
- R11: A command write naming object 0 or a number above 32 changes no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | CPU command write strobe |
| cmd_obj | input | 6 | Target object number, 1..32 |
| cmd_arb | input | 1 | Command carries valid and direction |
| cmd_ctrl | input | 1 | Command carries the control flags |
| cmd_valid | input | 1 | Valid value to load |
| cmd_dir | input | 1 | Direction value to load (1 = transmit object) |
| cmd_txrq | input | 1 | Transmit request value to load |
| cmd_newdat | input | 1 | New data value to load |
| cmd_intpnd | input | 1 | Interrupt pending value to load |
| cmd_rmten | input | 1 | Remote-enable value to load |
| cmd_umask | input | 1 | Use-mask value to load |
| tx_done | input | 1 | Engine: frame of `tx_obj` sent successfully |
| tx_obj | input | 6 | Object number of the sent frame |
| rx_data | input | 1 | Engine: data frame stored into `rx_obj` |
| rx_remote | input | 1 | Engine: remote frame matched `rx_obj` |
| rx_obj | input | 6 | Object number of the received frame |
| txrq_lo | output | 16 | Transmit request, objects 1..16 |
| txrq_hi | output | 16 | Transmit request, objects 17..32 |
| newdat_lo | output | 16 | New data, objects 1..16 |
| newdat_hi | output | 16 | New data, objects 17..32 |
| intpnd_lo | output | 16 | Interrupt pending, objects 1..16 |
| intpnd_hi | output | 16 | Interrupt pending, objects 17..32 |
| valid_lo | output | 16 | Valid, objects 1..16 |
| valid_hi | output | 16 | Valid, objects 17..32 |
| int_id | output | 6 | Highest-priority pending object, 0 = none |
| tx_ok | output | 1 | One-cycle pulse after each transmit-done |

## Verification
Every flag sits in a register that drives a status word directly. A wrong next-state decision therefore shows up at the ports one cycle after the event that caused it. If a remote-frame decision is wrong, that object's transmit-request bit in the packed word is wrong at once. A wrong interrupt-pending bit moves `int_id` in the same cycle. Each table step compares the target object's transmit request and `int_id` right after the step's clock edge. The directed tests compare whole words, so a bit that lands in the wrong half or a write that hits the wrong object is caught.

// File: rtl/can_stat_pkg.sv
package can_stat_pkg;

    // Per-object flags plus the configuration bits that steer remote handling
    typedef struct packed {
        logic txrq;
        logic newdat;
        logic intpnd;
        logic valid;
        logic dir;
        logic rmten;
        logic umask;
    } obj_state_t;

    localparam obj_state_t OBJ_RESET = '0;

endpackage

// File: rtl/can_obj_cell.sv
module can_obj_cell
    import can_stat_pkg::*;
#(
    parameter int OBJ_W   = 6,
    parameter int OBJ_NUM = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [OBJ_W-1:0] cmd_obj,
    input  logic             cmd_arb,
    input  logic             cmd_ctrl,
    input  logic             cmd_valid,
    input  logic             cmd_dir,
    input  logic             cmd_txrq,
    input  logic             cmd_newdat,
    input  logic             cmd_intpnd,
    input  logic             cmd_rmten,
    input  logic             cmd_umask,
    input  logic             tx_done,
    input  logic [OBJ_W-1:0] tx_obj,
    input  logic             rx_data,
    input  logic             rx_remote,
    input  logic [OBJ_W-1:0] rx_obj,
    output obj_state_t       state
);

    localparam logic [OBJ_W-1:0] MY_NUM = OBJ_W'(OBJ_NUM);

    obj_state_t st_d, st_q;
    logic cpu_hit, tx_hit, rxd_hit, rmt_hit;

    assign cpu_hit = cmd_wr && (cmd_obj == MY_NUM);
    assign tx_hit  = tx_done && (tx_obj == MY_NUM);
    assign rxd_hit = rx_data && (rx_obj == MY_NUM);
    assign rmt_hit = rx_remote && (rx_obj == MY_NUM);

    // CPU writes are applied first so that engine events override them
    always_comb begin
        st_d = st_q;
        if (cpu_hit && cmd_arb) begin
            st_d.valid = cmd_valid;
            st_d.dir   = cmd_dir;
        end
        if (cpu_hit && cmd_ctrl) begin
            st_d.txrq   = cmd_txrq;
            st_d.newdat = cmd_newdat;
            st_d.intpnd = cmd_intpnd;
            st_d.rmten  = cmd_rmten;
            st_d.umask  = cmd_umask;
        end
        if (tx_hit) begin
            st_d.txrq   = 1'b0;
            st_d.intpnd = 1'b1;
        end
        if (rxd_hit) begin
            st_d.newdat = 1'b1;
            st_d.intpnd = 1'b1;
        end
        if (rmt_hit && st_q.dir) begin
            if (st_q.rmten) begin
                st_d.txrq = 1'b1;
            end else if (st_q.umask) begin
                st_d.txrq = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= OBJ_RESET;
        else        st_q <= st_d;
    end

    assign state = st_q;

    a_r3_tx_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_hit && !rmt_hit) |=> (!st_q.txrq && st_q.intpnd));

    a_r4_remote_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_hit && st_q.dir && st_q.rmten) |=> st_q.txrq);

    a_r5_remote_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_hit && st_q.dir && !st_q.rmten && st_q.umask) |=> !st_q.txrq);

    a_r6_remote_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rmt_hit && !(st_q.dir && (st_q.rmten || st_q.umask)) && !tx_hit
         && !(cpu_hit && cmd_ctrl)) |=> $stable(st_q.txrq));

    a_r8_rx_flags: assert property (@(posedge clk) disable iff (!rst_n)
        rxd_hit |=> (st_q.newdat && st_q.intpnd));

    a_r10_engine_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_hit && cmd_ctrl && !cmd_intpnd && rxd_hit) |=> st_q.intpnd);

endmodule

// File: rtl/can_int_arb.sv
module can_int_arb #(
    parameter int N_OBJ = 32,
    parameter int ID_W  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_OBJ-1:0] pend,
    output logic [ID_W-1:0]  int_id
);

    logic [ID_W-1:0] id_d;

    // Scan from the top so the lowest pending number is the last to win
    always_comb begin
        id_d = '0;
        for (int i = N_OBJ - 1; i >= 0; i--) begin
            if (pend[i]) id_d = ID_W'(i + 1);
        end
    end

    assign int_id = id_d;

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_id == '0) == (pend == '0)));

    a_r9_id_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id != '0) |-> pend[int_id - 1'b1]);

endmodule

// File: rtl/can_msg_status.sv
module can_msg_status
    import can_stat_pkg::*;
#(
    parameter int N_OBJ = 32,
    parameter int OBJ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [OBJ_W-1:0] cmd_obj,
    input  logic             cmd_arb,
    input  logic             cmd_ctrl,
    input  logic             cmd_valid,
    input  logic             cmd_dir,
    input  logic             cmd_txrq,
    input  logic             cmd_newdat,
    input  logic             cmd_intpnd,
    input  logic             cmd_rmten,
    input  logic             cmd_umask,
    input  logic             tx_done,
    input  logic [OBJ_W-1:0] tx_obj,
    input  logic             rx_data,
    input  logic             rx_remote,
    input  logic [OBJ_W-1:0] rx_obj,
    output logic [15:0]      txrq_lo,
    output logic [15:0]      txrq_hi,
    output logic [15:0]      newdat_lo,
    output logic [15:0]      newdat_hi,
    output logic [15:0]      intpnd_lo,
    output logic [15:0]      intpnd_hi,
    output logic [15:0]      valid_lo,
    output logic [15:0]      valid_hi,
    output logic [OBJ_W-1:0] int_id,
    output logic             tx_ok
);

    localparam int HALF = N_OBJ / 2;

    obj_state_t       obj_st [N_OBJ];
    logic [N_OBJ-1:0] txrq_v, newdat_v, intpnd_v, valid_v;
    logic             tx_ok_d, tx_ok_q;

    for (genvar g = 0; g < N_OBJ; g++) begin : g_obj
        can_obj_cell #(
            .OBJ_W  (OBJ_W),
            .OBJ_NUM(g + 1)
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_wr    (cmd_wr),
            .cmd_obj   (cmd_obj),
            .cmd_arb   (cmd_arb),
            .cmd_ctrl  (cmd_ctrl),
            .cmd_valid (cmd_valid),
            .cmd_dir   (cmd_dir),
            .cmd_txrq  (cmd_txrq),
            .cmd_newdat(cmd_newdat),
            .cmd_intpnd(cmd_intpnd),
            .cmd_rmten (cmd_rmten),
            .cmd_umask (cmd_umask),
            .tx_done   (tx_done),
            .tx_obj    (tx_obj),
            .rx_data   (rx_data),
            .rx_remote (rx_remote),
            .rx_obj    (rx_obj),
            .state     (obj_st[g])
        );
        assign txrq_v[g]   = obj_st[g].txrq;
        assign newdat_v[g] = obj_st[g].newdat;
        assign intpnd_v[g] = obj_st[g].intpnd;
        assign valid_v[g]  = obj_st[g].valid;
    end

    can_int_arb #(
        .N_OBJ(N_OBJ),
        .ID_W (OBJ_W)
    ) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (intpnd_v),
        .int_id(int_id)
    );

    // Transmit-OK follows every completion, independent of the valid bit
    always_comb begin
        tx_ok_d = tx_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_ok_q <= 1'b0;
        else        tx_ok_q <= tx_ok_d;
    end

    assign tx_ok     = tx_ok_q;
    assign txrq_lo   = txrq_v[HALF-1:0];
    assign txrq_hi   = txrq_v[N_OBJ-1:HALF];
    assign newdat_lo = newdat_v[HALF-1:0];
    assign newdat_hi = newdat_v[N_OBJ-1:HALF];
    assign intpnd_lo = intpnd_v[HALF-1:0];
    assign intpnd_hi = intpnd_v[N_OBJ-1:HALF];
    assign valid_lo  = valid_v[HALF-1:0];
    assign valid_hi  = valid_v[N_OBJ-1:HALF];

    a_r3_tx_ok_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> tx_ok);

    a_r3_tx_ok_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_done |=> !tx_ok);

endmodule

// File: tb/can_msg_status_bench.sv
module can_msg_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 0, cmd_arb = 0, cmd_ctrl = 0, cmd_valid = 0, cmd_dir = 0;
    logic       cmd_txrq = 0, cmd_newdat = 0, cmd_intpnd = 0, cmd_rmten = 0, cmd_umask = 0;
    logic [5:0] cmd_obj = 0, tx_obj = 0, rx_obj = 0;
    logic       tx_done = 0, rx_data = 0, rx_remote = 0;
    logic [15:0] txrq_lo, txrq_hi, newdat_lo, newdat_hi;
    logic [15:0] intpnd_lo, intpnd_hi, valid_lo, valid_hi;
    logic [5:0] int_id;
    logic       tx_ok;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    can_msg_status u_can_msg_status (.*);

    // Vector: op[20:18] obj[17:12] arg[11:7] exp_txrq[6] exp_id[5:0]
    // op 1 arb (arg[1]=valid arg[0]=dir), 2 ctrl (arg = txrq,newdat,intpnd,rmten,umask),
    // op 3 tx done, 4 data rx, 5 remote rx
    localparam int NV = 17;
    localparam logic [20:0] VEC [NV] = '{
        {3'd1, 6'd5,  5'b00011, 1'b0, 6'd0},
        {3'd2, 6'd5,  5'b00010, 1'b0, 6'd0},
        {3'd5, 6'd5,  5'b00000, 1'b1, 6'd0},   // R4
        {3'd3, 6'd5,  5'b00000, 1'b0, 6'd5},   // R3
        {3'd4, 6'd20, 5'b00000, 1'b0, 6'd5},   // R8
        {3'd2, 6'd5,  5'b00000, 1'b0, 6'd20},  // R7
        {3'd1, 6'd9,  5'b00011, 1'b0, 6'd20},
        {3'd2, 6'd9,  5'b10001, 1'b1, 6'd20},
        {3'd5, 6'd9,  5'b00000, 1'b0, 6'd20},  // R5
        {3'd2, 6'd9,  5'b10000, 1'b1, 6'd20},
        {3'd5, 6'd9,  5'b00000, 1'b1, 6'd20},  // R6 umask 0
        {3'd1, 6'd12, 5'b00010, 1'b0, 6'd20},
        {3'd2, 6'd12, 5'b00010, 1'b0, 6'd20},
        {3'd5, 6'd12, 5'b00000, 1'b0, 6'd20},  // R6 dir 0
        {3'd3, 6'd32, 5'b00000, 1'b0, 6'd20},
        {3'd2, 6'd20, 5'b00000, 1'b0, 6'd32},  // R9
        {3'd2, 6'd32, 5'b00000, 1'b0, 6'd0}    // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmd_wr = 0; cmd_arb = 0; cmd_ctrl = 0;
        tx_done = 0; rx_data = 0; rx_remote = 0;
    endtask

    task automatic set_arb(input logic [5:0] o, input logic [1:0] a);
        cmd_wr = 1; cmd_arb = 1; cmd_obj = o; {cmd_valid, cmd_dir} = a;
    endtask

    task automatic set_ctrl(input logic [5:0] o, input logic [4:0] a);
        cmd_wr = 1; cmd_ctrl = 1; cmd_obj = o;
        {cmd_txrq, cmd_newdat, cmd_intpnd, cmd_rmten, cmd_umask} = a;
    endtask

    initial begin
        for (int w = 0; w < 5000 && !done; w++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] tx_all;
        repeat (3) @(negedge clk);
        check("R1 txrq", {txrq_hi, txrq_lo}, 0);
        check("R1 newdat", {newdat_hi, newdat_lo}, 0);
        check("R1 intpnd", {intpnd_hi, intpnd_lo}, 0);
        check("R1 valid", {valid_hi, valid_lo}, 0);
        check("R1 id/txok", {int_id, tx_ok}, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [2:0] op;
            logic [5:0] ob;
            logic [4:0] ar;
            op = VEC[i][20:18]; ob = VEC[i][17:12]; ar = VEC[i][11:7];
            case (op)
                3'd1: set_arb(ob, ar[1:0]);
                3'd2: set_ctrl(ob, ar);
                3'd3: begin tx_done = 1; tx_obj = ob; end
                3'd4: begin rx_data = 1; rx_obj = ob; end
                default: begin rx_remote = 1; rx_obj = ob; end
            endcase
            tick();
            tx_all = {txrq_hi, txrq_lo};
            check($sformatf("R4/R5/R6/R7 txrq step %0d", i), tx_all[ob - 1], VEC[i][6]);
            check($sformatf("R9 int_id step %0d", i), int_id, VEC[i][5:0]);
        end

        // R2 packing at the half boundary
        rx_data = 1; rx_obj = 1;  tick();
        rx_data = 1; rx_obj = 16; tick();
        rx_data = 1; rx_obj = 17; tick();
        check("R2 newdat_lo", newdat_lo, 16'h8001);
        check("R2 newdat_hi", newdat_hi, 16'h0001);
        check("R2 valid_lo", valid_lo, 16'h0910);
        check("R2 txrq_lo", txrq_lo, 16'h0100);
        check("R9 lowest id", int_id, 1);

        // R10 CPU clear and engine set in the same cycle
        set_ctrl(1, 5'b00000); rx_data = 1; rx_obj = 1; tick();
        check("R10 intpnd kept", intpnd_lo[0], 1);
        set_ctrl(1, 5'b00000); tick();
        check("R7 intpnd cleared", intpnd_lo[0], 0);
        check("R9 next id", int_id, 16);

        // R11 out-of-range command numbers
        set_arb(0, 2'b11);  tick();
        set_arb(33, 2'b11); tick();
        check("R11 valid_lo", valid_lo, 16'h0910);
        check("R11 valid_hi", valid_hi, 16'h0000);

        // R3 completion after the valid bit was dropped
        set_arb(7, 2'b10); tick();
        set_ctrl(7, 5'b10000); tick();
        check("R7 txrq set", txrq_lo[6], 1);
        set_arb(7, 2'b00); tick();
        tx_done = 1; tx_obj = 7; tick();
        check("R3 tx_ok", tx_ok, 1);
        check("R3 txrq cleared", txrq_lo[6], 0);
        check("R3 valid stays 0", valid_lo[6], 0);
        check("R3 intpnd id", int_id, 7);
        tick();
        check("R3 tx_ok one cycle", tx_ok, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule